// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Register Slave

This block is a slave on a two-wire serial bus (clock line plus open-drain data line). It samples both lines on its own system clock and finds bus start and stop conditions. It compares the first byte of each transfer against its 7-bit device address and acknowledges when they match. Access to its small bank of 8-bit registers is indirect. A write transfer first loads an 8-bit pointer and may then store one data byte at the register that pointer selects. A read transfer returns the byte the pointer currently selects.

The device address has two parts. The five upper bits reset to `01011` and can be rewritten at runtime through a configuration register that sits at a parameterised pointer value. The two lower bits are taken from strap pins, which are sampled only while reset is asserted. Software can therefore move the device on the bus, but it cannot move it off the slot the board wiring gave it. The data line is never driven high. The block only asserts an enable that pulls the line low.

Top module: `serial_reg_slave`

## Requirements
- R1: While reset is asserted the device address becomes {5'b01011, strapPins}. The strap pins are sampled only during reset, so later changes on them have no effect. With both straps low the address is 7'h2C.
- R2: A fall of the data line while the clock line is high is a START. It restarts reception of an address byte at any point in a transfer.
- R3: The byte after START holds the address in bits 7:1, MSB first, and the direction in bit 0. On a match the block pulls the data line low for the ninth clock. On a mismatch it drives nothing and ignores all bytes until the next START.
- R4: In a write transfer (direction 0) the first data byte is stored in the pointer, and that byte is acknowledged.
- R5: The second data byte of a write transfer is stored in the register the pointer selects, and that byte is acknowledged.
- R6: Any data byte after the second in a write transfer is acknowledged but changes nothing. The pointer never increments.
- R7: In a read transfer (direction 1) the block sends the selected byte MSB first and changes its data-line drive only while the clock line is low.
- R8: A master NACK on the ninth clock of a read ends the read, and the data line is released. A master ACK causes the same byte to be sent again, because the pointer is unchanged.
- R9: Pointer value CFG_PTR (default 8'h0F) holds the configuration register. Writing it loads data bits 6:2 into the five upper address bits, and the strapped bits are kept. Reading it returns {1'b0, device address}.
- R10: After an address change the block answers only the new address, until the next change or reset.
- R11: A STOP or START that arrives before the eighth data bit is clocked aborts the byte. Nothing is written.
- R12: Pointers at or above NUM_REGS (default 4), other than CFG_PTR, read as 8'h00, and writes to them are ignored.
- R13: A rise of the data line while the clock line is high is a STOP. After a STOP the block releases the data line and waits for a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Asynchronous active-low reset; strap pins are sampled while it is low |
| scl | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| strapPins | input | 2 | Board straps for the two low address bits |
| sdaDriveLow | output | 1 | Open-drain enable: 1 pulls the data line low |

## Verification
Two situations are hard to reach from the ports. The first is a transfer cut short inside a byte. The bench master clocks only four bits of a data byte and then issues a STOP, or in another test a repeated START. It then reads the register back to show that no partial byte was stored. The second is the strap sampling. The straps can only be exercised through a second reset with non-zero strap values, after which the pins are changed while the block runs. Probes of both the old and the new address then show that only the value latched during reset counts, including after the upper address bits are rewritten.

// File: rtl/srs_pkg.sv
package srs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_END,
    ST_ACK,
    ST_WR,
    ST_WR_END,
    ST_RD,
    ST_RD_ACK,
    ST_RD_AGAIN
  } ctrlState_t;

  // strobes from control into the datapath
  typedef struct packed {
    logic shiftRx;
    logic commitPtr;
    logic commitData;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;

  // bus events and status from the datapath to control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic sdaBit;
    logic addrHit;
    logic rwBit;
    logic txMsb;
  } busEvent_t;

endpackage

// File: rtl/srs_datapath.sv
module srs_datapath
  import srs_pkg::*;
#(
  parameter int         NUM_REGS    = 4,
  parameter logic [7:0] CFG_PTR     = 8'h0F,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scl,
  input  logic       sdaIn,
  input  logic [1:0] strapPins,
  input  dpStrobe_t  strobe,
  output busEvent_t  evt,
  output logic [7:0] ptrQ,
  output logic [6:0] devAddr,
  output logic       sclSync
);

  localparam int         IDXW  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [8:0] NREG9 = 9'(NUM_REGS);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclD, sdaD, sclS, sdaS;
  logic [7:0] rxByte, txShift, readByte;
  logic [4:0] upperAddr;
  logic [1:0] strapQ;
  logic [7:0] bank [NUM_REGS];

  // line synchronisers, idle level high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], scl};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS    = sclPipe[SYNC_STAGES-1];
  assign sdaS    = sdaPipe[SYNC_STAGES-1];
  assign sclSync = sclS;

  assign evt.sclRise   = sclS & ~sclD;
  assign evt.sclFall   = ~sclS & sclD;
  assign evt.startSeen = sclS & sclD & sdaD & ~sdaS;
  assign evt.stopSeen  = sclS & sclD & ~sdaD & sdaS;
  assign evt.sdaBit    = sdaS;
  assign evt.addrHit   = (rxByte[7:1] == devAddr);
  assign evt.rwBit     = rxByte[0];
  assign evt.txMsb     = txShift[7];

  // receive shifter and pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      ptrQ   <= '0;
    end else begin
      if (strobe.shiftRx)   rxByte <= {rxByte[6:0], sdaS};
      if (strobe.commitPtr) ptrQ   <= rxByte;
    end
  end

  // device address: rewritable upper part, strapped lower part
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upperAddr <= 5'b01011;
      strapQ    <= strapPins;
    end else if (strobe.commitData && ptrQ == CFG_PTR) begin
      upperAddr <= rxByte[6:2];
    end
  end

  assign devAddr = {upperAddr, strapQ};

  // register bank
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        bank[i] <= '0;
      else if (strobe.commitData && ptrQ == 8'(i))
        bank[i] <= rxByte;
    end
  end

  always_comb begin
    if (ptrQ == CFG_PTR)
      readByte = {1'b0, devAddr};
    else if ({1'b0, ptrQ} < NREG9)
      readByte = bank[ptrQ[IDXW-1:0]];
    else
      readByte = 8'h00;
  end

  // transmit shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      txShift <= '0;
    else if (strobe.loadTx)
      txShift <= readByte;
    else if (strobe.shiftTx)
      txShift <= {txShift[6:0], 1'b0};
  end

endmodule

// File: rtl/srs_ctrl.sv
module srs_ctrl
  import srs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  busEvent_t  evt,
  output dpStrobe_t  strobe,
  output ctrlState_t state,
  output logic       sdaDriveLow
);

  ctrlState_t nxt;
  logic [2:0] bitCnt;
  logic [1:0] wrCount;
  logic       isRead;
  logic       cntInc, cntClr, setDir, wrInc, wrClr;

  always_comb begin
    nxt    = state;
    strobe = '0;
    cntInc = 1'b0;
    cntClr = 1'b0;
    setDir = 1'b0;
    wrInc  = 1'b0;
    wrClr  = 1'b0;
    if (evt.stopSeen) begin
      nxt = ST_IDLE;
    end else if (evt.startSeen) begin
      nxt    = ST_ADDR;
      cntClr = 1'b1;
      wrClr  = 1'b1;
    end else begin
      unique case (state)
        ST_ADDR, ST_WR: if (evt.sclRise) begin
          strobe.shiftRx = 1'b1;
          cntInc = 1'b1;
          if (bitCnt == 3'd7) nxt = (state == ST_ADDR) ? ST_ADDR_END : ST_WR_END;
        end
        ST_ADDR_END: if (evt.sclFall) begin
          if (evt.addrHit) begin
            nxt    = ST_ACK;
            setDir = 1'b1;
          end else begin
            nxt = ST_IDLE;
          end
        end
        ST_ACK: if (evt.sclFall) begin
          cntClr = 1'b1;
          if (isRead) begin
            strobe.loadTx = 1'b1;
            nxt = ST_RD;
          end else begin
            nxt = ST_WR;
          end
        end
        ST_WR_END: if (evt.sclFall) begin
          strobe.commitPtr  = (wrCount == 2'd0);
          strobe.commitData = (wrCount == 2'd1);
          wrInc = (wrCount != 2'd2);
          nxt   = ST_ACK;
        end
        ST_RD: if (evt.sclFall) begin
          cntInc = 1'b1;
          if (bitCnt == 3'd7) nxt = ST_RD_ACK;
          else strobe.shiftTx = 1'b1;
        end
        ST_RD_ACK: if (evt.sclRise) nxt = evt.sdaBit ? ST_IDLE : ST_RD_AGAIN;
        ST_RD_AGAIN: if (evt.sclFall) begin
          strobe.loadTx = 1'b1;
          cntClr = 1'b1;
          nxt = ST_RD;
        end
        default: nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      wrCount <= '0;
      isRead  <= 1'b0;
    end else begin
      state <= nxt;
      if (cntClr)      bitCnt <= '0;
      else if (cntInc) bitCnt <= bitCnt + 3'd1;
      if (wrClr)       wrCount <= '0;
      else if (wrInc)  wrCount <= wrCount + 2'd1;
      if (setDir)      isRead <= evt.rwBit;
    end
  end

  assign sdaDriveLow = (state == ST_ACK) || (state == ST_RD && !evt.txMsb);

endmodule

// File: rtl/serial_reg_slave.sv
module serial_reg_slave
  import srs_pkg::*;
#(
  parameter int         NUM_REGS    = 4,
  parameter logic [7:0] CFG_PTR     = 8'h0F,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scl,
  input  logic       sdaIn,
  input  logic [1:0] strapPins,
  output logic       sdaDriveLow
);

  dpStrobe_t  strobe;
  busEvent_t  evt;
  ctrlState_t ctrlState;
  logic [7:0] ptrQ;
  logic [6:0] devAddr;
  logic       sclSync;
  logic       stopSeen;

  srs_datapath #(
    .NUM_REGS   (NUM_REGS),
    .CFG_PTR    (CFG_PTR),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .scl      (scl),
    .sdaIn    (sdaIn),
    .strapPins(strapPins),
    .strobe   (strobe),
    .evt      (evt),
    .ptrQ     (ptrQ),
    .devAddr  (devAddr),
    .sclSync  (sclSync)
  );

  srs_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .evt        (evt),
    .strobe     (strobe),
    .state      (ctrlState),
    .sdaDriveLow(sdaDriveLow)
  );

  assign stopSeen = evt.stopSeen;

endmodule

// File: rtl/srs_checker.sv
module srs_checker
  import srs_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       sclSync,
  input logic       sdaDriveLow,
  input logic       stopSeen,
  input logic [6:0] devAddr,
  input logic [7:0] ptrQ,
  input ctrlState_t ctrlState
);

  AST_DRIVE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !sclSync); // R7

  AST_RELEASE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !sdaDriveLow); // R13

  AST_STRAP_BITS_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    $stable(devAddr[1:0])); // R1

  AST_UPPER_ADDR_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(devAddr[6:2]) |-> $past(ctrlState) == ST_WR_END); // R9

  AST_PTR_HELD_IN_READ: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_RD || ctrlState == ST_RD_ACK || ctrlState == ST_RD_AGAIN)
      |-> $stable(ptrQ)); // R8

endmodule

bind serial_reg_slave srs_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sclSync    (sclSync),
  .sdaDriveLow(sdaDriveLow),
  .stopSeen   (stopSeen),
  .devAddr    (devAddr),
  .ptrQ       (ptrQ),
  .ctrlState  (ctrlState)
);

// File: tb/test_serial_reg_slave.sv
`timescale 1ns/1ps
module test_serial_reg_slave;

  localparam real        Q   = 50.0;
  localparam logic [7:0] CFG = 8'h0F;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic [1:0] strapPins = 2'b00;
  logic sdaDriveLow;
  wire  sdaBus = mSda & ~sdaDriveLow;

  int nChecks = 0;
  int nFail   = 0;

  always #2.5 clk = ~clk;

  serial_reg_slave i_serial_reg_slave (
    .clk        (clk),
    .rstN       (rstN),
    .scl        (mScl),
    .sdaIn      (sdaBus),
    .strapPins  (strapPins),
    .sdaDriveLow(sdaDriveLow)
  );

  // {pointer, write data, expected read-back}
  localparam logic [23:0] VEC [6] = '{
    {8'h00, 8'hA5, 8'hA5},
    {8'h01, 8'h3C, 8'h3C},
    {8'h03, 8'hFF, 8'hFF},
    {8'h02, 8'h00, 8'h00},
    {8'h07, 8'h99, 8'h00},
    {8'h00, 8'h5A, 8'h5A}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic doReset(input logic [1:0] straps);
    rstN = 1'b0;
    mScl = 1'b1;
    mSda = 1'b1;
    strapPins = straps;
    repeat (5) @(posedge clk);
    #1;
    rstN = 1'b1;
    #(Q);
  endtask

  task automatic busStart();
    mSda = 1'b1; #(Q);
    mScl = 1'b1; #(Q);
    mSda = 1'b0; #(Q);
    mScl = 1'b0; #(Q);
  endtask

  task automatic busStop();
    mSda = 1'b0; #(Q);
    mScl = 1'b1; #(Q);
    mSda = 1'b1; #(Q);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      mSda = b[i]; #(Q);
      mScl = 1'b1; #(2*Q);
      mScl = 1'b0; #(Q);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    sendBits(b, 8);
    mSda = 1'b1; #(Q);
    mScl = 1'b1; #(Q);
    acked = ~sdaBus; #(Q);
    mScl = 1'b0; #(Q);
  endtask

  task automatic recvByte(output logic [7:0] b, input logic masterAck);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #(Q); mScl = 1'b1;
      #(Q); b[i] = sdaBus;
      #(Q); mScl = 1'b0;
      #(Q);
    end
    mSda = ~masterAck; #(Q);
    mScl = 1'b1; #(2*Q);
    mScl = 1'b0; #(Q);
  endtask

  task automatic probe(input logic [6:0] a, output logic acked);
    busStart();
    sendByte({a, 1'b0}, acked);
    busStop();
  endtask

  task automatic writeReg(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d,
                          output logic ok);
    logic k0, k1, k2;
    busStart();
    sendByte({a, 1'b0}, k0);
    sendByte(p, k1);
    sendByte(d, k2);
    busStop();
    ok = k0 & k1 & k2;
  endtask

  task automatic readReg(input logic [6:0] a, input logic [7:0] p, output logic [7:0] d);
    logic k;
    busStart();
    sendByte({a, 1'b0}, k);
    sendByte(p, k);
    busStart();
    sendByte({a, 1'b1}, k);
    recvByte(d, 1'b0);
    busStop();
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired got running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin : main
    logic ok;
    logic [7:0] d, d2;

    doReset(2'b00);
    check("R13 reset release", {7'd0, sdaDriveLow}, 8'h00);
    probe(7'h2C, ok);
    check("R1 default address ack", {7'd0, ok}, 8'h01);
    busStart();
    sendByte({7'h2D, 1'b0}, ok);
    check("R3 mismatch no ack", {7'd0, ok}, 8'h00);
    sendByte(8'h00, ok);
    check("R3 idle after mismatch", {7'd0, ok}, 8'h00);
    busStop();

    // table of write/read-back vectors
    for (int v = 0; v < 6; v++) begin
      writeReg(7'h2C, VEC[v][23:16], VEC[v][15:8], ok);
      check("R5 write acked", {7'd0, ok}, 8'h01);
      readReg(7'h2C, VEC[v][23:16], d);
      check("R7 R12 read back", d, VEC[v][7:0]);
    end

    // pointer-only write, then plain read
    busStart(); sendByte({7'h2C, 1'b0}, ok); sendByte(8'h01, ok); busStop();
    busStart(); sendByte({7'h2C, 1'b1}, ok); recvByte(d, 1'b0); busStop();
    check("R4 pointer persists", d, 8'h3C);

    // extra write byte ignored
    busStart(); sendByte({7'h2C, 1'b0}, ok); sendByte(8'h02, ok);
    sendByte(8'h11, ok); sendByte(8'h22, ok);
    check("R6 extra byte acked", {7'd0, ok}, 8'h01);
    busStop();
    readReg(7'h2C, 8'h02, d);
    check("R6 extra byte ignored", d, 8'h11);

    // master ACK repeats byte, NACK ends read
    busStart(); sendByte({7'h2C, 1'b0}, ok); sendByte(8'h00, ok);
    busStart(); sendByte({7'h2C, 1'b1}, ok);
    recvByte(d, 1'b1); recvByte(d2, 1'b0);
    check("R8 first byte", d, 8'h5A);
    check("R8 repeated byte", d2, 8'h5A);
    check("R8 released after NACK", {7'd0, sdaDriveLow}, 8'h00);
    busStop();
    check("R13 released after stop", {7'd0, sdaDriveLow}, 8'h00);

    // STOP and START inside a data byte
    busStart(); sendByte({7'h2C, 1'b0}, ok); sendByte(8'h03, ok);
    sendBits(8'h00, 4); busStop();
    readReg(7'h2C, 8'h03, d);
    check("R11 stop aborts byte", d, 8'hFF);
    busStart(); sendByte({7'h2C, 1'b0}, ok); sendByte(8'h03, ok);
    sendBits(8'h00, 4);
    busStart(); sendByte({7'h2C, 1'b1}, ok);
    check("R2 restart mid byte acked", {7'd0, ok}, 8'h01);
    recvByte(d, 1'b0); busStop();
    check("R11 start aborts byte", d, 8'hFF);

    // address change
    writeReg(7'h2C, CFG, 8'h7F, ok);
    probe(7'h2C, ok);
    check("R10 old address ignored", {7'd0, ok}, 8'h00);
    probe(7'h7C, ok);
    check("R10 new address ack", {7'd0, ok}, 8'h01);
    readReg(7'h7C, CFG, d);
    check("R9 config read", d, 8'h7C);
    writeReg(7'h7C, CFG, 8'h57, ok);
    probe(7'h54, ok);
    check("R9 straps kept", {7'd0, ok}, 8'h01);

    // strap sampling at reset
    doReset(2'b10);
    strapPins = 2'b00;
    probe(7'h2E, ok);
    check("R1 strapped address ack", {7'd0, ok}, 8'h01);
    probe(7'h2C, ok);
    check("R1 straps sampled only in reset", {7'd0, ok}, 8'h00);
    writeReg(7'h2E, CFG, 8'h00, ok);
    probe(7'h02, ok);
    check("R9 strap bits survive rewrite", {7'd0, ok}, 8'h01);
    readReg(7'h02, 8'h00, d);
    check("R1 bank cleared by reset", d, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule